// File: doc/BRIEF.md
# Interrupt Mask and Sticky Status Register Group

This block is the interrupt control register group of a serial peripheral. It holds a 14-bit interrupt mask and a 14-bit status register. The mask cannot be written directly. Software turns mask bits on through a set port and turns them off through a clear port. Both of these ports are write-only and read back as zero. Each cycle, raw event pulses from the serial datapath pass through the mask. Any event that passes is latched into the status register, where it stays until software writes a 1 to that bit. A single interrupt line is high while any status bit is pending under a bit that is enabled in the mask.

A separate read address shows the raw event vector unmasked, so software can poll conditions it has masked out. The block uses a simple register bus with a word address, a write strobe, write data and combinational read data.

All views use one bit layout. Bit i of the mask, the status and the raw view always refers to the same event. From bit 0 upward the events are: receive trigger level reached, receive queue empty, receive queue full, transmit queue empty, transmit queue full, receive overrun, framing error, parity error, receive idle timeout, modem line change, transmit trigger level reached, transmit queue nearly full, transmit overflow, and receive break.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the mask and the status register are all zeros, and `irq_o` is low.
- R2: A write to address 0 (set port) turns on every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value. The new mask is readable at address 2 in the cycle after the write edge.
- R3: A write to address 1 (clear port) turns off every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: A read of address 0 or address 1 always returns zero, whatever the mask holds.
- R5: On a clock edge where raw event bit i is 1 and mask bit i is 1, status bit i (read at address 3) becomes 1. A raw event whose mask bit is 0 leaves status bit i unchanged.
- R6: Status bits are sticky. A write to address 3 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 stay as they are.
- R7: If a status clear and a new masked event hit the same bit on the same edge, the bit ends up set.
- R8: `irq_o` is high exactly when some bit is set in both the status register and the mask. Clearing the mask bit of a pending status bit drops `irq_o`, and the status bit stays set.
- R9: Write-data bits 14 and above are ignored. Mask and status reads return zero in bits 14 and above.
- R10: A read of address 4 returns the current raw event vector, zero-extended and not masked.
- R11: Addresses 5 to 7 read as zero. Writes to them change neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address of the register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| raw_evt_i | input | 14 | Raw event pulses from the datapath |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `raw_evt_i`, `addr_i`, `we_i` and `wdata_i` are stable around the rising edge. They also assume that at most one register access happens per cycle, so the set and clear ports never carry a write on the same edge. The bench meets both assumptions. It changes every input only on the falling edge and issues each write as a single-cycle strobe. It holds event pulses for exactly one cycle so that the expected status can be counted per edge.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

   localparam int unsigned IRQ_SRC_N = 14;

   // Word addresses of the register group (3-bit address space)
   typedef enum logic [2:0] {
      RA_SET  = 3'd0,
      RA_CLR  = 3'd1,
      RA_MASK = 3'd2,
      RA_STAT = 3'd3,
      RA_RAW  = 3'd4
   } reg_addr_e;

   // Event bit positions shared by mask, status and raw view
   localparam int unsigned EV_RX_TRIG  = 0;
   localparam int unsigned EV_RX_EMPTY = 1;
   localparam int unsigned EV_RX_FULL  = 2;
   localparam int unsigned EV_TX_EMPTY = 3;
   localparam int unsigned EV_TX_FULL  = 4;
   localparam int unsigned EV_OVERRUN  = 5;
   localparam int unsigned EV_FRAMING  = 6;
   localparam int unsigned EV_PARITY   = 7;
   localparam int unsigned EV_TIMEOUT  = 8;
   localparam int unsigned EV_MODEM    = 9;
   localparam int unsigned EV_TX_TRIG  = 10;
   localparam int unsigned EV_TX_NFULL = 11;
   localparam int unsigned EV_TX_OVF   = 12;
   localparam int unsigned EV_RX_BRK   = 13;

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode #(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [NUM_SRC-1:0] set_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] w1c_o
);
   import irq_regs_pkg::*;

   logic [NUM_SRC-1:0] wbits;
   logic               unused_hi;

   assign wbits     = wdata_i[NUM_SRC-1:0];
   assign unused_hi = ^wdata_i[DATA_W-1:NUM_SRC];

   always_comb begin
      set_o = '0;
      clr_o = '0;
      w1c_o = '0;
      if (we_i) begin
         if (addr_i == ADDR_W'(RA_SET))  set_o = wbits;
         if (addr_i == ADDR_W'(RA_CLR))  clr_o = wbits;
         if (addr_i == ADDR_W'(RA_STAT)) w1c_o = wbits;
      end
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned NUM_SRC = 14
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] mask_o
);
   logic [NUM_SRC-1:0] mask_q;

   // A clear on the same bit as a set wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= (mask_q | set_i) & ~clr_i;
   end

   assign mask_o = mask_q;

   assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_i & ~clr_i)) |=> ((mask_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

   assert_mask_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|clr_i) |=> ((mask_q & $past(clr_i)) == '0));

   assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i == '0 && clr_i == '0) |=> $stable(mask_q));

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int unsigned NUM_SRC = 14
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] w1c_i,
   output logic [NUM_SRC-1:0] stat_o
);
   logic [NUM_SRC-1:0] stat_q;

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      // New event beats a clear on the same edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                   stat_q[b] <= 1'b0;
         else if (evt_i[b] && en_i[b])  stat_q[b] <= 1'b1;
         else if (w1c_i[b])             stat_q[b] <= 1'b0;
      end
   end

   assign stat_o = stat_q;

   assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(evt_i & en_i)) |=> ((stat_q & $past(evt_i & en_i)) == $past(evt_i & en_i)));

   assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(stat_q & ~w1c_i)) |=> ((stat_q & $past(stat_q & ~w1c_i)) == $past(stat_q & ~w1c_i)));

   assert_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(~stat_q & ~(evt_i & en_i))) |=> ((stat_q & $past(~stat_q & ~(evt_i & en_i))) == '0));

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
   parameter int unsigned NUM_SRC = 14,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic [NUM_SRC-1:0] stat_i,
   input  logic [NUM_SRC-1:0] raw_i,
   output logic [DATA_W-1:0]  rdata_o
);
   import irq_regs_pkg::*;

   always_comb begin
      rdata_o = '0;
      if      (addr_i == ADDR_W'(RA_MASK)) rdata_o = DATA_W'(mask_i);
      else if (addr_i == ADDR_W'(RA_STAT)) rdata_o = DATA_W'(stat_i);
      else if (addr_i == ADDR_W'(RA_RAW))  rdata_o = DATA_W'(raw_i);
   end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
   parameter int unsigned NUM_SRC     = irq_regs_pkg::IRQ_SRC_N,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter bit          IRQ_REG_OUT = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                we_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   input  logic [NUM_SRC-1:0]  raw_evt_i,
   output logic                irq_o
);
   import irq_regs_pkg::*;

   localparam int unsigned PEND_W = NUM_SRC;

   if (DATA_W <= NUM_SRC) begin : g_chk_width
      $error("irq_ctrl_top: DATA_W must exceed NUM_SRC");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("irq_ctrl_top: ADDR_W must be at least 3");
   end

   logic [NUM_SRC-1:0] set_v, clr_v, w1c_v, mask_v, stat_v;
   logic [PEND_W-1:0]  pend_v;

   irq_wr_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .addr_i (addr_i), .we_i (we_i), .wdata_i (wdata_i),
      .set_o  (set_v),  .clr_o (clr_v), .w1c_o (w1c_v)
   );

   irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (set_v), .clr_i (clr_v), .mask_o (mask_v)
   );

   irq_sticky_bank #(.NUM_SRC(NUM_SRC)) u_stat (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .evt_i (raw_evt_i), .en_i (mask_v), .w1c_i (w1c_v), .stat_o (stat_v)
   );

   irq_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .addr_i (addr_i), .mask_i (mask_v), .stat_i (stat_v),
      .raw_i  (raw_evt_i), .rdata_o (rdata_o)
   );

   assign pend_v = stat_v & mask_v;

   if (IRQ_REG_OUT) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= |pend_v;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |pend_v;
   end

   assert_rd_wonly_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == ADDR_W'(RA_SET) || addr_i == ADDR_W'(RA_CLR)) |-> (rdata_o == '0));

   assert_rd_hi_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i != ADDR_W'(RA_RAW)) |-> (rdata_o[DATA_W-1:NUM_SRC] == '0));

   assert_irq_needs_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_v == '0 && $past(mask_v) == '0) |-> !irq_o);

endmodule

// File: tb/irq_ctrl_top_tb_top.sv
module irq_ctrl_top_tb_top;
   localparam int NS = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NS-1:0] raw = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_ctrl_top dut_i (
      .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .we_i (we),
      .wdata_i (wdata), .rdata_o (rdata), .raw_evt_i (raw), .irq_o (irq)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulse(input logic [NS-1:0] v);
      @(negedge clk);
      raw = v;
      @(negedge clk);
      raw = '0;
   endtask

   task automatic reset_dut();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reset_dut();
      rd(3'd2, d); check("R1 mask", d, 32'h0);
      rd(3'd3, d); check("R1 status", d, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_set_clr();
      logic [31:0] d;
      reset_dut();
      wr(3'd0, 32'h0000_0005);
      wr(3'd0, 32'h0000_2100);
      rd(3'd2, d); check("R2 set accumulates", d, 32'h0000_2105);
      wr(3'd1, 32'h0000_0101);
      rd(3'd2, d); check("R3 clear selected", d, 32'h0000_2004);
      rd(3'd0, d); check("R4 set port reads zero", d, 32'h0);
      rd(3'd1, d); check("R4 clear port reads zero", d, 32'h0);
   endtask

   task automatic t_capture();
      logic [31:0] d;
      reset_dut();
      wr(3'd0, 32'h0000_2001);
      pulse(14'h3FFF);
      rd(3'd3, d); check("R5 masked capture, bits 0 and 13", d, 32'h0000_2001);
      check("R8 irq pending", {31'b0, irq}, 32'h1);
      pulse(14'h0000);
      rd(3'd3, d); check("R6 sticky without event", d, 32'h0000_2001);
      wr(3'd3, 32'h0000_0001);
      rd(3'd3, d); check("R6 w1c bit 0 only", d, 32'h0000_2000);
      wr(3'd1, 32'h0000_2000);
      check("R8 irq drops when mask cleared", {31'b0, irq}, 32'h0);
      rd(3'd3, d); check("R8 status kept after mask clear", d, 32'h0000_2000);
      wr(3'd3, 32'h0000_2000);
      rd(3'd3, d); check("R6 w1c bit 13", d, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      reset_dut();
      wr(3'd0, 32'h0000_000C);
      pulse(14'h000C);
      @(negedge clk);
      addr = 3'd3; we = 1'b1; wdata = 32'h0000_000C; raw = 14'h0004;
      @(negedge clk);
      we = 1'b0; wdata = '0; raw = '0;
      rd(3'd3, d); check("R7 event wins over clear", d, 32'h0000_0004);
   endtask

   task automatic t_wide_and_raw();
      logic [31:0] d;
      reset_dut();
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd2, d); check("R9 upper set bits ignored", d, 32'h0000_3FFF);
      wr(3'd1, 32'hFFFF_C000);
      rd(3'd2, d); check("R9 upper clear bits ignored", d, 32'h0000_3FFF);
      wr(3'd1, 32'h0000_3FFF);
      @(negedge clk);
      raw = 14'h2A5A;
      addr = 3'd4;
      #1 check("R10 raw view unmasked", rdata, 32'h0000_2A5A);
      @(negedge clk);
      raw = '0;
      rd(3'd3, d); check("R5 masked-out event not captured", d, 32'h0);
   endtask

   task automatic t_unused_addr();
      logic [31:0] d;
      reset_dut();
      wr(3'd0, 32'h0000_0010);
      pulse(14'h0010);
      for (int a = 5; a < 8; a++) begin
         wr(3'(a), 32'hFFFF_FFFF);
         rd(3'(a), d); check("R11 unused address reads zero", d, 32'h0);
      end
      rd(3'd2, d); check("R11 mask untouched", d, 32'h0000_0010);
      rd(3'd3, d); check("R11 status untouched", d, 32'h0000_0010);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_set_clr();
      t_capture();
      t_collide();
      t_wide_and_raw();
      t_unused_addr();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule